// File: doc/BRIEF.md
# Digital Single-Bit Noise-Shaping Requantizer

This block takes the multi-level code produced once per sample by an analog second-order converter stage and turns it into a one-bit stream at the same sample rate. It is a purely digital fourth-order error-shaping loop. The input code is centred on zero and fed forward straight to the decision point, so the signal reaches the bitstream with unity gain at low frequency. The error made by cutting the code down to one bit passes through a fourth-order high-pass shaping response. Its largest gain at half the sample rate is near 1.5.

The loop is a chain of four delaying integrators. Only the first one receives the feedback. The decision point adds the input to a weighted sum of all four integrator states. Each weight is one power of two, or the sum or difference of two powers of two, so the loop uses only shifts and adds. Every integrator has its own word length, and each is wide enough that for in-range inputs no stage wraps or loses bits. Each sample is marked by a valid strobe. A decimation filter downstream recovers the audio.

Top module: `sdr_requantizer`

## Requirements
- R1: An input code c in 0..11 maps to the odd level u = 2c - 11, from -11 to +11. Codes 12 to 15 are clamped and map to +11.
- R2: A sample is taken at each rising clock edge where `in_valid` is 1. Its output bit appears on `out_bit` after that same edge and stays there until the next accepted sample.
- R3: For each accepted sample, the decision value is w = u + 0.75·s1 + 0.21875·s2 + 0.03125·s3 + 0.00146484375·s4, using the integrator states s1..s4 before the update. `out_bit` is 1 when w >= 0 and 0 otherwise. The feedback is v = +F when the bit is 1 and -F when it is 0, with F = 32 by default. The states then update as s1 += u - v and sk += s(k-1) for k = 2..4, using the old values.
- R4: For a constant input code, the mean of the bitstream (with a 1 counted as +F and a 0 as -F) over 2048 samples matches u to within one level.
- R5: For any sequence of in-range levels, no integrator ever goes beyond its signed range. The default widths are 14, 18, 22 and 26 bits.
- R6: While `in_valid` is 0, `out_bit` and every integrator state stay the same. When sampling resumes, the output continues the same sequence as if there had been no gap.
- R7: A synchronous reset clears all four integrators to zero and sets `out_bit` to 1. Any `in_valid` seen during reset is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a valid input code for this cycle |
| in_code | input | 4 | Multi-level input code (0..11; larger values are clamped) |
| out_bit | output | 1 | Registered single-bit output stream |

## Verification
The bit for a sample is registered, so it appears on `out_bit` after the rising edge that accepts the strobe. The bench's driver sets up the code just after one rising edge and pushes the bit its real-valued loop model expects. The monitor pops that bit at the falling edge that follows the accepting edge, and it only does so in cycles where the strobe was seen at that edge. Hold and reset checks look at `out_bit` two nanoseconds after each later edge. Long-run averages are built only from bits the monitor has already compared.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  // Decision point: input term plus four state terms.
  localparam int NTERM = 5;
  localparam int NINT  = 4;
  // The decision sum carries this many fraction bits, so every weight is an integer.
  localparam int FRAC  = 11;

  // Each weight is (1 << SH_A) +/- (1 << SH_B) in units of 2^-FRAC.
  // SH_B < 0 means the second term is absent.
  // Order: input, state 1, state 2, state 3, state 4.
  localparam int FF_SH_A  [NTERM] = '{11, 11, 9, 6, 1};
  localparam int FF_SH_B  [NTERM] = '{-1,  9, 6, -1, 0};
  localparam bit FF_NEG_B [NTERM] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

  // Odd level, symmetric about zero, for an input code; large codes clamp.
  function automatic int level_of(input int code, input int nlev);
    int c;
    c = (code > nlev - 1) ? nlev - 1 : code;
    return 2 * c - (nlev - 1);
  endfunction

endpackage

// File: rtl/sdr_level_map.sv
module sdr_level_map #(
  parameter int NLEV   = 12,
  parameter int CODE_W = 4,
  parameter int LVL_W  = 7
) (
  input  logic [CODE_W-1:0]       code,
  output logic signed [LVL_W-1:0] level
);
  int lv;
  always_comb begin
    lv    = sdr_pkg::level_of(int'(code), NLEV);
    level = LVL_W'(lv);
  end
endmodule

// File: rtl/sdr_integrator.sv
module sdr_integrator #(
  parameter int W     = 14,
  parameter int ACC_W = 26
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] q,
  output logic                    ovf
);
  logic signed [W-1:0] st;
  logic signed [ACC_W:0] nxt;

  assign nxt = (ACC_W+1)'(st) + (ACC_W+1)'(din);

  // The next value fits W bits only if its top bits, down to bit W-1, are all equal.
  assign ovf = en && !((&nxt[ACC_W:W-1]) || !(|nxt[ACC_W:W-1]));
  assign q   = ACC_W'(st);

  always_ff @(posedge clk) begin
    if (rst)     st <= '0;
    else if (en) st <= nxt[W-1:0];
  end
endmodule

// File: rtl/sdr_ff_term.sv
module sdr_ff_term #(
  parameter int IN_W  = 26,
  parameter int OUT_W = 39,
  parameter int SH_A  = 0,
  parameter int SH_B  = -1,
  parameter bit NEG_B = 1'b0
) (
  input  logic signed [IN_W-1:0]  x,
  output logic signed [OUT_W-1:0] y
);
  logic signed [OUT_W-1:0] xe;
  assign xe = OUT_W'(x);

  if (SH_B < 0) begin : g_one
    assign y = xe <<< SH_A;
  end else if (NEG_B) begin : g_diff
    assign y = (xe <<< SH_A) - (xe <<< SH_B);
  end else begin : g_sum
    assign y = (xe <<< SH_A) + (xe <<< SH_B);
  end
endmodule

// File: rtl/sdr_requantizer.sv
module sdr_requantizer #(
  parameter int NLEV   = 12,
  parameter int FB_MAG = 32,
  parameter int INT1_W = 14,
  parameter int INT2_W = 18,
  parameter int INT3_W = 22,
  parameter int INT4_W = 26,
  localparam int CODE_W = $clog2(NLEV)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_bit
);
  import sdr_pkg::*;

  localparam int LVL_W = $clog2(FB_MAG + NLEV) + 2;
  localparam int ACC_W = INT4_W;
  localparam int SUM_W = ACC_W + FRAC + 2;
  localparam int IW [NINT] = '{INT1_W, INT2_W, INT3_W, INT4_W};

  logic signed [LVL_W-1:0] lvl, fb, err;
  logic signed [ACC_W-1:0] st_q [NINT];
  logic [NINT-1:0]         ovf_v;
  logic signed [SUM_W-1:0] term [NTERM];
  logic signed [SUM_W-1:0] acc;
  logic                    dec;
  logic                    en;

  // Named wires for the bound checker.
  logic                    ovf_any;
  logic signed [ACC_W-1:0] st1, st2;

  assign en = in_valid && !rst;

  sdr_level_map #(.NLEV(NLEV), .CODE_W(CODE_W), .LVL_W(LVL_W)) u_map (
    .code(in_code), .level(lvl)
  );

  // Input term feeds forward to the decision point.
  sdr_ff_term #(.IN_W(LVL_W), .OUT_W(SUM_W), .SH_A(FF_SH_A[0]),
                .SH_B(FF_SH_B[0]), .NEG_B(FF_NEG_B[0])) u_ff_in (
    .x(lvl), .y(term[0])
  );

  for (genvar i = 0; i < NINT; i++) begin : g_int
    logic signed [ACC_W-1:0] din;
    if (i == 0) begin : g_head
      assign din = ACC_W'(err);
    end else begin : g_chain
      assign din = st_q[i-1];
    end
    sdr_integrator #(.W(IW[i]), .ACC_W(ACC_W)) u_int (
      .clk(clk), .rst(rst), .en(en), .din(din), .q(st_q[i]), .ovf(ovf_v[i])
    );
    sdr_ff_term #(.IN_W(ACC_W), .OUT_W(SUM_W), .SH_A(FF_SH_A[i+1]),
                  .SH_B(FF_SH_B[i+1]), .NEG_B(FF_NEG_B[i+1])) u_ff (
      .x(st_q[i]), .y(term[i+1])
    );
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTERM; k++) acc = acc + term[k];
  end

  assign dec = ~acc[SUM_W-1];
  assign fb  = dec ? LVL_W'(FB_MAG) : -LVL_W'(FB_MAG);
  assign err = lvl - fb;

  always_ff @(posedge clk) begin
    if (rst)     out_bit <= 1'b1;
    else if (en) out_bit <= dec;
  end

  assign ovf_any = |ovf_v;
  assign st1     = st_q[0];
  assign st2     = st_q[1];
endmodule

// File: rtl/sdr_requantizer_chk.sv
module sdr_requantizer_chk #(
  parameter int NLEV   = 12,
  parameter int FB_MAG = 32,
  parameter int LVL_W  = 7,
  parameter int ACC_W  = 26
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic signed [LVL_W-1:0] lvl,
  input logic                    out_bit,
  input logic signed [ACC_W-1:0] st1,
  input logic signed [ACC_W-1:0] st2,
  input logic                    ovf_any
);
  // R1: the mapped level is odd and lies within +/-(NLEV-1).
  p_level_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (lvl[0] && lvl <= LVL_W'(NLEV - 1) && lvl >= -LVL_W'(NLEV - 1)));

  // R3: the first integrator takes the level minus the fed-back bit.
  p_feedback_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> longint'(st1) == longint'($past(st1)) + longint'($past(lvl))
                 - (out_bit ? longint'(FB_MAG) : -longint'(FB_MAG)));

  // R3: the second integrator accumulates the first.
  p_chain_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> longint'(st2) == longint'($past(st2)) + longint'($past(st1)));

  // R5: no integrator wraps.
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst) !ovf_any);

  // R6: with no strobe, the output and the state are held.
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_bit) && $stable(st1) && $stable(st2)));

  // R7: reset clears the state and sets the output to 1.
  p_reset_r7: assert property (@(posedge clk)
    rst |=> (out_bit && st1 == '0 && st2 == '0));
endmodule

bind sdr_requantizer sdr_requantizer_chk #(
  .NLEV(NLEV), .FB_MAG(FB_MAG), .LVL_W(LVL_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .lvl(lvl), .out_bit(out_bit),
  .st1(st1), .st2(st2), .ovf_any(ovf_any)
);

// File: tb/tb_sdr_requantizer.sv
module tb_sdr_requantizer;
  localparam int NLEV = 12;
  localparam int F    = 32;
  localparam int W [4] = '{14, 18, 22, 26};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] in_code = '0;
  logic       out_bit;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sdr_requantizer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code), .out_bit(out_bit)
  );

  // Real-valued loop model built from the requirements.
  real x [4];
  real xmax [4];
  bit  exp_q [$];
  logic samp_v = 1'b0;
  longint obs_sum = 0;
  longint obs_n   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0f expected %0f", req, what, act, expv);
    end
  endtask

  function automatic int lvl_model(input int c);
    int cc;
    cc = (c > NLEV - 1) ? NLEV - 1 : c;
    return 2 * cc - (NLEV - 1);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin x[i] = 0.0; xmax[i] = 0.0; end
  endtask

  function automatic bit model_step(input int c);
    real u, w, v;
    bit b;
    u = real'(lvl_model(c));
    w = u + 0.75 * x[0] + 0.21875 * x[1] + 0.03125 * x[2] + 0.00146484375 * x[3];
    b = (w >= 0.0);
    v = b ? real'(F) : -real'(F);
    x[3] = x[3] + x[2];
    x[2] = x[2] + x[1];
    x[1] = x[1] + x[0];
    x[0] = x[0] + u - v;
    for (int i = 0; i < 4; i++) begin
      if (x[i] > xmax[i]) xmax[i] = x[i];
      if (-x[i] > xmax[i]) xmax[i] = -x[i];
    end
    return b;
  endfunction

  // Driver: puts up one sample just after a rising edge and pushes the expected bit.
  task automatic send(input int c);
    @(posedge clk); #2;
    in_code  = 4'(c);
    in_valid = 1'b1;
    exp_q.push_back(model_step(c));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compares at the falling edge after the edge that accepted the sample.
  always @(posedge clk) samp_v <= in_valid && !rst;

  always @(negedge clk) begin
    if (samp_v) begin
      bit e;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected output bit", real'(out_bit), -1.0);
      end else begin
        e = exp_q.pop_front();
        check(out_bit == e, "R3", "bitstream vs loop model", real'(out_bit), real'(e));
      end
      obs_sum += out_bit ? 1 : -1;
      obs_n   += 1;
    end
  end

  task automatic range_check(input string what);
    for (int i = 0; i < 4; i++)
      check(xmax[i] < real'(longint'(1) << (W[i] - 1)), "R5", what, xmax[i],
            real'(longint'(1) << (W[i] - 1)));
  endtask

  // R4: constant code, mean of the +/-F stream over 2048 samples.
  task automatic dc_run(input int c);
    real avg;
    for (int i = 0; i < 256; i++) send(c);
    idle(2);
    obs_sum = 0; obs_n = 0;
    for (int i = 0; i < 2048; i++) send(c);
    idle(2);
    avg = real'(obs_sum) * real'(F) / real'(obs_n);
    check(obs_n == 2048, "R2", "one bit per strobe", real'(obs_n), 2048.0);
    check(avg - real'(lvl_model(c)) <= 1.0 && real'(lvl_model(c)) - avg <= 1.0,
          "R4", "DC mean", avg, real'(lvl_model(c)));
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    check(out_bit == 1'b1, "R7", "output after reset", real'(out_bit), 1.0);
    // Strobe during reset is ignored.
    in_valid = 1'b1; in_code = 4'd0;
    @(posedge clk); #2;
    check(out_bit == 1'b1, "R7", "strobe in reset ignored", real'(out_bit), 1.0);
    rst = 1'b0; in_valid = 1'b0;

    // R1 mapping is seen through the DC means, including a clamped code.
    dc_run(0);
    dc_run(11);
    dc_run(6);
    dc_run(3);
    dc_run(15);   // R1: clamp to +11
    range_check("DC runs");

    // Sine-shaped code sequence, full code range.
    for (int n = 0; n < 4096; n++) begin
      real s;
      s = 5.5 + 5.5 * $sin(2.0 * 3.14159265358979 * real'(n) / 256.0);
      send(int'(s + 0.5));
    end
    idle(2);
    range_check("sine run");

    // R6: gap in the strobe holds the output; the sequence then continues.
    for (int n = 0; n < 37; n++) send((n * 5) % 12);
    begin
      logic held;
      @(posedge clk); #2;
      in_valid = 1'b0;
      held = out_bit;
      for (int i = 0; i < 12; i++) begin
        in_code = 4'(i);
        @(posedge clk); #2;
        check(out_bit == held, "R6", "output held without strobe", real'(out_bit), real'(held));
      end
    end
    for (int n = 0; n < 200; n++) send((n * 7) % 12);
    idle(2);

    // R7: reset in mid-run clears the state; the model restarts from zero.
    @(posedge clk); #2;
    rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); #2;
    check(out_bit == 1'b1, "R7", "output after mid-run reset", real'(out_bit), 1.0);
    rst = 1'b0;
    model_reset();
    for (int n = 0; n < 300; n++) send(n % 12);
    idle(2);
    check(exp_q.size() == 0, "R2", "all expected bits consumed", real'(exp_q.size()), 0.0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule